// File: doc/BRIEF.md
# Reference Selection and Holdover Controller

This block decides which of two timing references drives a downstream phase-locked loop, and in which operating state that loop runs: locked to a reference, holding its last frequency, or running free. A two-bit mode input either fixes the loop state and reference directly, which is manual operation, or hands control to an event-driven state machine that reacts to two loss-of-reference indicators, which is automatic operation.

In automatic operation, losing the preferred reference puts the loop into holdover and starts an internal guard timer. Short outages are ridden out without a reference change. If the outage outlasts the guard time, the controller fails over to the backup reference. It returns to the preferred reference once that reference is healthy again. Losing both references forces holdover. A role-swap input makes the secondary input the preferred one. Every change of the active reference raises a one-cycle strobe, which a downstream phase-step corrector can use.

All outputs are registered. They respond on the first clock edge after the inputs change.

Top module: `refsel_ctrl`

## Requirements
- R1: While reset is asserted and after reset is released, `ref_active` is 0, `pll_state` is 0 (locked), `guard_run` is 0 and `switch_strobe` is 0.
- R2: In manual operation, `mode_sel` 2'b00 gives `pll_state` 0 (locked), 2'b01 gives `pll_state` 1 (holdover) and 2'b10 gives `pll_state` 2 (freerun). The state appears one clock after the mode is applied.
- R3: In manual operation, `ref_active` equals `ref_sel`, where 0 means the primary input and 1 means the secondary input. The loss inputs have no effect on any output.
- R4: With `mode_sel` 2'b11 (automatic), a lost preferred reference while the backup is good gives `pll_state` 1 and `guard_run` 1 on the next clock. `ref_active` is unchanged.
- R5: If the preferred reference recovers while the guard timer runs, the controller returns to `pll_state` 0 on that reference, and no strobe is raised.
- R6: If the preferred reference stays lost for GUARD_CYCLES clocks of holdover, the next clock switches `ref_active` to the backup with `pll_state` 0.
- R7: While on the backup, clearing the preferred reference's loss indicator returns `ref_active` to the preferred input with `pll_state` 0.
- R8: In automatic operation, both loss indicators high gives `pll_state` 1 with `ref_active` held and `guard_run` 0, for as long as both stay lost. If only the backup returns, the controller locks to the backup.
- R9: In automatic operation with `ref_sel` 1, the secondary input is preferred: `ref_active` is 1 when healthy, `loss_sec` acts as the preferred loss indicator, and failover goes to the primary input (0).
- R10: Each change of `ref_active` is accompanied by `switch_strobe` high for exactly the cycle in which the new value first appears. `switch_strobe` is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | 00 locked, 01 holdover, 10 freerun (manual), 11 automatic |
| ref_sel | input | 1 | Manual: chosen input. Automatic: 1 swaps preferred and backup roles |
| loss_pri | input | 1 | High when the primary input is unusable |
| loss_sec | input | 1 | High when the secondary input is unusable |
| ref_active | output | 1 | Reference feeding the loop, 0 primary, 1 secondary |
| pll_state | output | 2 | 0 locked, 1 holdover, 2 freerun |
| guard_run | output | 1 | Guard timer running in preferred-reference holdover |
| switch_strobe | output | 1 | One-cycle pulse on each reference change |

## Verification
The assertions assume that the mode, select and loss inputs are synchronous to `clk` and stable across each edge. They also assume that reset is held for at least one edge before operation. The bench drives every input on the falling edge and samples outputs on the following falling edge, so each input set is seen by exactly one rising edge before it is checked. The guard timer is shortened through its parameter, so expiry windows stay a handful of cycles long.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
   typedef enum logic [1:0] {
      PLL_LOCK = 2'd0,
      PLL_HOLD = 2'd1,
      PLL_FREE = 2'd2
   } pll_state_e;

   typedef enum logic [1:0] {
      AS_PREF     = 2'd0,
      AS_HOLD_PREF = 2'd1,
      AS_BACKUP   = 2'd2,
      AS_HOLD_ALL = 2'd3
   } auto_state_e;

   localparam logic [1:0] MODE_AUTO = 2'b11;
endpackage

// File: rtl/refsel_guard_timer.sv
module refsel_guard_timer #(
   parameter int GUARD_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   localparam int CW = $clog2(GUARD_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(GUARD_CYCLES - 1);

   logic [CW-1:0] cnt_q;

   generate
      if (GUARD_CYCLES < 2) begin : g_bad_param
         $error("GUARD_CYCLES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || !run) cnt_q <= '0;
      else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
   end

   assign done = run && (cnt_q == LAST);

   // R6: the count never passes the guard limit
   p_guard_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);
endmodule

// File: rtl/refsel_auto_fsm.sv
module refsel_auto_fsm
   import refsel_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic auto_en,
   input  logic loss_pref,
   input  logic loss_bk,
   input  logic guard_done,
   output auto_state_e state_q,
   output logic        on_backup_q
);
   auto_state_e state_d;
   logic        bk_d;

   always_comb begin
      state_d = state_q;
      bk_d    = on_backup_q;
      unique case (state_q)
         AS_PREF: begin
            if (loss_pref && loss_bk) state_d = AS_HOLD_ALL;
            else if (loss_pref)       state_d = AS_HOLD_PREF;
         end
         AS_HOLD_PREF: begin
            if (!loss_pref)                state_d = AS_PREF;
            else if (loss_bk)              state_d = AS_HOLD_ALL;
            else if (guard_done) begin
               state_d = AS_BACKUP;
               bk_d    = 1'b1;
            end
         end
         AS_BACKUP: begin
            if (!loss_pref) begin
               state_d = AS_PREF;
               bk_d    = 1'b0;
            end else if (loss_bk) state_d = AS_HOLD_ALL;
         end
         AS_HOLD_ALL: begin
            if (!loss_pref) begin
               state_d = AS_PREF;
               bk_d    = 1'b0;
            end else if (!loss_bk) begin
               state_d = AS_BACKUP;
               bk_d    = 1'b1;
            end
         end
         default: state_d = AS_PREF;
      endcase
      if (!auto_en) begin
         state_d = AS_PREF;
         bk_d    = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= AS_PREF;
         on_backup_q <= 1'b0;
      end else begin
         state_q     <= state_d;
         on_backup_q <= bk_d;
      end
   end

   // R4: guarded holdover always sits on the preferred reference
   p_hold_on_pref_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == AS_HOLD_PREF) |-> !on_backup_q);
   // R5: recovery during the guard window returns to the preferred state
   p_recover_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && state_q == AS_HOLD_PREF && !loss_pref) |=> (state_q == AS_PREF));
endmodule

// File: rtl/refsel_ctrl.sv
module refsel_ctrl
   import refsel_pkg::*;
#(
   parameter int GUARD_CYCLES = 16,
   parameter bit ALLOW_SWAP   = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode_sel,
   input  logic       ref_sel,
   input  logic       loss_pri,
   input  logic       loss_sec,
   output logic       ref_active,
   output logic [1:0] pll_state,
   output logic       guard_run,
   output logic       switch_strobe
);
   logic        auto_in;
   logic        swap_in;
   logic        loss_pref;
   logic        loss_bk;
   logic        guard_done;
   logic [1:0]  mode_q;
   logic        sel_q;
   logic        ref_prev_q;
   auto_state_e ast_q;
   logic        on_bk_q;

   assign auto_in = (mode_sel == MODE_AUTO);

   generate
      if (ALLOW_SWAP) begin : g_swap
         assign swap_in = ref_sel;
      end else begin : g_noswap
         assign swap_in = 1'b0;
      end
   endgenerate

   assign loss_pref = swap_in ? loss_sec : loss_pri;
   assign loss_bk   = swap_in ? loss_pri : loss_sec;

   refsel_guard_timer #(.GUARD_CYCLES(GUARD_CYCLES)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (ast_q == AS_HOLD_PREF),
      .done (guard_done)
   );

   refsel_auto_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .auto_en    (auto_in),
      .loss_pref  (loss_pref),
      .loss_bk    (loss_bk),
      .guard_done (guard_done),
      .state_q    (ast_q),
      .on_backup_q(on_bk_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q     <= 2'b00;
         sel_q      <= 1'b0;
         ref_prev_q <= 1'b0;
      end else begin
         mode_q     <= mode_sel;
         sel_q      <= ref_sel;
         ref_prev_q <= ref_active;
      end
   end

   always_comb begin
      if (mode_q == MODE_AUTO) begin
         ref_active = on_bk_q ^ (ALLOW_SWAP ? sel_q : 1'b0);
         pll_state  = (ast_q == AS_HOLD_PREF || ast_q == AS_HOLD_ALL) ? PLL_HOLD : PLL_LOCK;
      end else begin
         ref_active = sel_q;
         pll_state  = mode_q;
      end
   end

   assign guard_run     = (mode_q == MODE_AUTO) && (ast_q == AS_HOLD_PREF);
   assign switch_strobe = (ref_active != ref_prev_q);

   // R2: manual mode sets the loop state on the next clock
   p_manual_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel != MODE_AUTO) |=> (pll_state == $past(mode_sel)));
   // R8: both references lost forces holdover
   p_both_lost_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_in && loss_pri && loss_sec) |=> (pll_state == PLL_HOLD && !guard_run));
   // R4: the guard timer only runs in holdover
   p_guard_in_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      guard_run |-> (pll_state == PLL_HOLD));
   // R10: a strobe never coincides with an unchanged reference across a stable input
   p_strobe_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
      switch_strobe |-> (ref_active != $past(ref_active)));
endmodule

// File: tb/refsel_ctrl_tb.sv
module refsel_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int G = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode_sel = 2'b00;
   logic       ref_sel = 1'b0;
   logic       loss_pri = 1'b0;
   logic       loss_sec = 1'b0;
   logic       ref_active;
   logic [1:0] pll_state;
   logic       guard_run;
   logic       switch_strobe;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   refsel_ctrl #(.GUARD_CYCLES(G)) u_dut (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ref_sel(ref_sel),
      .loss_pri(loss_pri), .loss_sec(loss_sec), .ref_active(ref_active),
      .pll_state(pll_state), .guard_run(guard_run), .switch_strobe(switch_strobe)
   );

   task automatic step(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic expect_out(input string tag, input logic r, input logic [1:0] s,
                             input logic g, input logic st);
      total++;
      if (ref_active !== r || pll_state !== s || guard_run !== g || switch_strobe !== st) begin
         bad++;
         $display("FAIL %s: got ref=%b st=%0d guard=%b strobe=%b exp ref=%b st=%0d guard=%b strobe=%b",
                  tag, ref_active, pll_state, guard_run, switch_strobe, r, s, g, st);
      end
   endtask

   task automatic set_in(input logic [1:0] m, input logic s, input logic lp, input logic ls);
      mode_sel = m; ref_sel = s; loss_pri = lp; loss_sec = ls;
   endtask

   task automatic t_reset;
      @(negedge clk);
      expect_out("R1 in reset", 1'b0, 2'd0, 1'b0, 1'b0);
      rst_n = 1'b1;
      step();
      expect_out("R1 after reset", 1'b0, 2'd0, 1'b0, 1'b0);
   endtask

   task automatic t_manual;
      set_in(2'b01, 1'b0, 1'b0, 1'b0); step();
      expect_out("R2 manual holdover", 1'b0, 2'd1, 1'b0, 1'b0);
      set_in(2'b10, 1'b0, 1'b0, 1'b0); step();
      expect_out("R2 manual freerun", 1'b0, 2'd2, 1'b0, 1'b0);
      set_in(2'b00, 1'b1, 1'b0, 1'b0); step();
      expect_out("R3 R10 manual secondary", 1'b1, 2'd0, 1'b0, 1'b1);
      step();
      expect_out("R10 strobe one cycle", 1'b1, 2'd0, 1'b0, 1'b0);
      set_in(2'b00, 1'b1, 1'b1, 1'b1); step(G + 2);
      expect_out("R3 losses ignored", 1'b1, 2'd0, 1'b0, 1'b0);
      set_in(2'b00, 1'b0, 1'b0, 1'b0); step();
      expect_out("R3 manual primary", 1'b0, 2'd0, 1'b0, 1'b1);
      step();
   endtask

   task automatic t_short_outage;
      set_in(2'b11, 1'b0, 1'b0, 1'b0); step();
      expect_out("R4 auto healthy", 1'b0, 2'd0, 1'b0, 1'b0);
      loss_pri = 1'b1; step();
      expect_out("R4 holdover at once", 1'b0, 2'd1, 1'b1, 1'b0);
      step(G - 2);
      expect_out("R5 still guarding", 1'b0, 2'd1, 1'b1, 1'b0);
      loss_pri = 1'b0; step();
      expect_out("R5 recovered no switch", 1'b0, 2'd0, 1'b0, 1'b0);
   endtask

   task automatic t_failover;
      loss_pri = 1'b1; step();
      step(G - 1);
      expect_out("R6 last guard cycle", 1'b0, 2'd1, 1'b1, 1'b0);
      step();
      expect_out("R6 R10 switched to backup", 1'b1, 2'd0, 1'b0, 1'b1);
      step();
      expect_out("R10 strobe cleared", 1'b1, 2'd0, 1'b0, 1'b0);
      loss_sec = 1'b1; step(G + 3);
      expect_out("R8 both lost from backup", 1'b1, 2'd1, 1'b0, 1'b0);
      loss_sec = 1'b0; step();
      expect_out("R8 backup usable again", 1'b1, 2'd0, 1'b0, 1'b0);
      loss_pri = 1'b0; step();
      expect_out("R7 back to primary", 1'b0, 2'd0, 1'b0, 1'b1);
      step();
   endtask

   task automatic t_both_lost;
      loss_pri = 1'b1; loss_sec = 1'b1; step();
      expect_out("R8 both lost", 1'b0, 2'd1, 1'b0, 1'b0);
      step(G + 3);
      expect_out("R8 stays in holdover", 1'b0, 2'd1, 1'b0, 1'b0);
      loss_pri = 1'b0; loss_sec = 1'b0; step();
      expect_out("R8 primary returns", 1'b0, 2'd0, 1'b0, 1'b0);
   endtask

   task automatic t_swap;
      ref_sel = 1'b1; step();
      expect_out("R9 swap prefers secondary", 1'b1, 2'd0, 1'b0, 1'b1);
      loss_pri = 1'b1; step(2);
      expect_out("R9 primary loss is backup loss", 1'b1, 2'd0, 1'b0, 1'b0);
      loss_pri = 1'b0; loss_sec = 1'b1; step();
      expect_out("R9 preferred lost", 1'b1, 2'd1, 1'b1, 1'b0);
      step(G);
      expect_out("R9 failover to primary", 1'b0, 2'd0, 1'b0, 1'b1);
      loss_sec = 1'b0; step();
      expect_out("R9 R7 back to secondary", 1'b1, 2'd0, 1'b0, 1'b1);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_manual();
      t_short_outage();
      t_failover();
      t_both_lost();
      t_swap();
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule